// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a down-counting watchdog that software arms through a small word-addressed register port. When armed, it loads a preset count chosen by a 4-bit range code and decrements once per clock. When the count reaches zero, a timeout occurs and the counter reloads the same preset. In the direct mode a timeout starts a system reset pulse at once. In the escalating mode the first timeout raises an interrupt. If that interrupt is still set when the next timeout comes, the reset pulse follows.

Software keeps the watchdog quiet by writing a fixed key to the restart register. That write reloads the counter and drops any pending interrupt. A separate write clears the interrupt and leaves the count running. The reset pulse length comes from a 3-bit code. Once the watchdog is armed it stays armed until the block's own reset.

Register map (word index on `regAddr`): 0 control, 1 range, 2 restart, 3 count (read only), 4 status / interrupt clear.

Top module: `wdt_escalator`

## Requirements
- R1: After reset, every register reads 0, and both `wdtIrq` and `sysRstOut` are low.
- R2: Range code n (range register bits [3:0]) selects a preset of 2^(BASE_LOG2+n)-1, saturating at all ones. An arming write (control bit 0 set while disarmed) loads this preset on the same clock edge, and the preset is then readable at address 3.
- R3: While armed, the count drops by one per clock. On the clock after the count reads 0, a timeout occurs and the count reloads the preset, so the period is preset+1 cycles.
- R4: While disarmed, the count holds its value and neither output asserts. A restart write while disarmed has no effect.
- R5: In mode 0 (control bit 1 = 0), a timeout raises `sysRstOut` from the next cycle on and never raises `wdtIrq`.
- R6: The reset pulse lasts exactly 2^(c+1) cycles, where c is control bits [4:2] (2 to 256 cycles).
- R7: In mode 1 (control bit 1 = 1), a timeout with the interrupt clear sets `wdtIrq` and starts no reset.
- R8: In mode 1, a timeout with `wdtIrq` still set starts the reset pulse.
- R9: Writing exactly 32'h00000076 to address 2 while armed reloads the preset and clears the interrupt. Any other value written there has no effect.
- R10: Any write to address 4 clears the interrupt without reloading the count. Reading address 4 returns the interrupt in bit 0.
- R11: Writing control bit 0 as 0 while armed leaves the watchdog armed, and the count keeps running.
- R12: A timeout that occurs while a reset pulse is active neither restarts nor lengthens that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the block |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| wdtIrq | output | 1 | First-stage timeout interrupt |
| sysRstOut | output | 1 | System reset pulse, active high |

## Verification
The hardest state to reach from the ports is escalation in mode 1. The interrupt must survive a full second period untouched, and the reset pulse must then overlap further timeouts when it is longer than the period. The bench builds the block with a base exponent of 2, so periods run from 4 to 64 cycles. It sweeps range and pulse codes, keeps away from the restart and clear registers between timeouts, and compares every cycle against an arithmetic model of period, interrupt and pulse. Directed sequences then cover the mode 1 paths: restart, clear-without-reload, and escalation after a cleared interrupt.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_RANGE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_KICK   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd4;

  localparam logic [REG_W-1:0] KICK_KEY = 32'h0000_0076;

  typedef enum logic {
    MODE_RESET     = 1'b0,
    MODE_IRQ_FIRST = 1'b1
  } wdtMode_t;

  typedef struct packed {
    logic cntLoad;
    logic cntDec;
    logic pulseStart;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int BASE_LOG2 = 16,
  parameter int RANGE_W   = 4,
  parameter int PULSE_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  wdtStrobe_t         strobe,
  input  logic [RANGE_W-1:0] rangeCode,
  input  logic [PULSE_W-1:0] pulseCode,
  output logic [CNT_W-1:0]   count,
  output logic               cntZero,
  output logic               pulseActive
);
  localparam int MAX_SHIFT   = BASE_LOG2 + (1 << RANGE_W) - 1;
  localparam int SHIFT_W     = $clog2(MAX_SHIFT + 1);
  localparam int PULSE_CNT_W = (1 << PULSE_W) + 1;

  logic [SHIFT_W-1:0]     shiftAmt;
  logic [CNT_W-1:0]       presetVal;
  logic [PULSE_CNT_W-1:0] pulseLen;
  logic [PULSE_CNT_W-1:0] pulseCnt;

  assign shiftAmt = SHIFT_W'(BASE_LOG2) + SHIFT_W'(rangeCode);

  generate
    if (MAX_SHIFT < CNT_W) begin : g_noSat
      always_comb presetVal = (CNT_W'(1) << shiftAmt) - CNT_W'(1);
    end else begin : g_sat
      always_comb begin
        if (int'(shiftAmt) >= CNT_W) presetVal = '1;
        else presetVal = (CNT_W'(1) << shiftAmt) - CNT_W'(1);
      end
    end
  endgenerate

  assign pulseLen = PULSE_CNT_W'(2) << pulseCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.cntLoad) begin
      count <= presetVal;
    end else if (strobe.cntDec) begin
      count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.pulseStart) begin
      pulseCnt <= pulseLen;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - PULSE_CNT_W'(1);
    end
  end

  assign cntZero     = (count == '0);
  assign pulseActive = (pulseCnt != '0);
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int RANGE_W = 4,
  parameter int PULSE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  input  logic [CNT_W-1:0]   count,
  input  logic               cntZero,
  input  logic               pulseActive,
  output wdtStrobe_t         strobe,
  output logic [RANGE_W-1:0] rangeCode,
  output logic [PULSE_W-1:0] pulseCode,
  output logic               enabled,
  output wdtMode_t           modeSel,
  output logic               irqPending
);
  logic ctrlWr, rangeWr, clrWr, kickHit, armHit, timeout, escalate;

  assign ctrlWr   = regWe && (regAddr == ADDR_CTRL);
  assign rangeWr  = regWe && (regAddr == ADDR_RANGE);
  assign clrWr    = regWe && (regAddr == ADDR_STATUS);
  assign kickHit  = enabled && regWe && (regAddr == ADDR_KICK) && (regWdata == KICK_KEY);
  assign armHit   = ctrlWr && regWdata[0] && !enabled;
  assign timeout  = enabled && cntZero && !kickHit;
  assign escalate = timeout && ((modeSel == MODE_RESET) || irqPending);

  always_comb begin
    strobe.cntLoad    = armHit || kickHit || timeout;
    strobe.cntDec     = enabled && !cntZero && !kickHit;
    strobe.pulseStart = escalate && !pulseActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled   <= 1'b0;
      modeSel   <= MODE_RESET;
      pulseCode <= '0;
      rangeCode <= '0;
    end else begin
      if (ctrlWr) begin
        enabled   <= enabled | regWdata[0];
        modeSel   <= wdtMode_t'(regWdata[1]);
        pulseCode <= regWdata[2 +: PULSE_W];
      end
      if (rangeWr) rangeCode <= regWdata[RANGE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending <= 1'b0;
    end else if (timeout && (modeSel == MODE_IRQ_FIRST) && !irqPending) begin
      irqPending <= 1'b1;
    end else if (kickHit || clrWr) begin
      irqPending <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL:   regRdata = REG_W'({pulseCode, modeSel, enabled});
      ADDR_RANGE:  regRdata = REG_W'(rangeCode);
      ADDR_COUNT:  regRdata = REG_W'(count);
      ADDR_STATUS: regRdata = REG_W'(irqPending);
      default:     regRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int BASE_LOG2 = 16,
  parameter int RANGE_W   = 4,
  parameter int PULSE_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              wdtIrq,
  output logic              sysRstOut
);
  wdtStrobe_t         strobe;
  logic [RANGE_W-1:0] rangeCode;
  logic [PULSE_W-1:0] pulseCode;
  logic [CNT_W-1:0]   count;
  logic               cntZero;
  logic               pulseActive;
  logic               enabled;
  wdtMode_t           modeSel;

  wdt_control #(.CNT_W(CNT_W), .RANGE_W(RANGE_W), .PULSE_W(PULSE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .count(count), .cntZero(cntZero), .pulseActive(pulseActive),
    .strobe(strobe), .rangeCode(rangeCode), .pulseCode(pulseCode), .enabled(enabled),
    .modeSel(modeSel), .irqPending(wdtIrq)
  );

  wdt_datapath #(.CNT_W(CNT_W), .BASE_LOG2(BASE_LOG2), .RANGE_W(RANGE_W), .PULSE_W(PULSE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rangeCode(rangeCode), .pulseCode(pulseCode),
    .count(count), .cntZero(cntZero), .pulseActive(pulseActive)
  );

  assign sysRstOut = pulseActive;
endmodule

// File: rtl/wdt_escalator_checker.sv
module wdt_escalator_checker
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regWdata,
  input logic [CNT_W-1:0]  count,
  input logic              enabled,
  input wdtMode_t          modeSel,
  input logic              wdtIrq,
  input logic              sysRstOut
);
  logic kickWr, armWr;
  assign kickWr = regWe && (regAddr == ADDR_KICK) && (regWdata == KICK_KEY);
  assign armWr  = regWe && (regAddr == ADDR_CTRL) && regWdata[0];

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    enabled |=> enabled); // R11

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (enabled && count != '0 && !kickWr) |=> (count == $past(count) - CNT_W'(1))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !armWr) |=> $stable(count)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> (!sysRstOut && !wdtIrq)); // R4

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtIrq) |-> ($past(modeSel) == MODE_IRQ_FIRST && $past(count) == '0)); // R7

  AST_RST_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> ($past(enabled) && $past(count) == '0)); // R5

  AST_ESCALATE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sysRstOut) && $past(modeSel) == MODE_IRQ_FIRST) |-> $past(wdtIrq)); // R8
endmodule

bind wdt_escalator wdt_escalator_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .count(count), .enabled(enabled), .modeSel(modeSel), .wdtIrq(wdtIrq),
  .sysRstOut(sysRstOut)
);

// File: tb/tb_wdt_escalator.sv
`timescale 1ns/1ps
module tb_wdt_escalator;
  localparam int BASE = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        wdtIrq, sysRstOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  wdt_escalator #(.CNT_W(32), .BASE_LOG2(BASE), .RANGE_W(4), .PULSE_W(3)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .wdtIrq(wdtIrq), .sysRstOut(sysRstOut)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = 32'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic doReset();
    regWe = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int p, t, l, mp, mi;
    bit tmo, esc;

    // R1: reset state
    doReset();
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 register reset value", v, 0);
    end
    chk("R1 irq at reset", wdtIrq, 0);
    chk("R1 reset out at reset", sysRstOut, 0);

    // R4: disarmed holds, restart ignored
    wr(3'd1, 32'd1);
    wr(3'd2, 32'h76);
    repeat (20) @(negedge clk);
    rd(3'd3, v);
    chk("R4 count held while disarmed", v, 0);
    chk("R4 no irq while disarmed", wdtIrq, 0);
    chk("R4 no reset while disarmed", sysRstOut, 0);

    // Mode 0 sweep: R2 R3 R5 R6 R12
    for (int n = 0; n < 5; n++) begin
      for (int c = 0; c < 8; c++) begin
        doReset();
        wr(3'd1, 32'(n));
        p = (1 << (BASE + n)) - 1; t = p + 1; l = 2 << c; mp = 0;
        regAddr = 3'd3;
        wr(3'd0, 32'((c << 2) | 1));
        for (int k = 0; k <= p + l + 3; k++) begin
          if (k > 0) begin
            @(negedge clk);
            tmo = (k % t) == 0;
            if (tmo && mp == 0) mp = l;
            else if (mp != 0) mp--;
          end
          rd(3'd3, v);
          if (k == 0) chk("R2 preset after arming", v, p);
          else chk("R3 count value", v, p - (k % t));
          chk("R5/R6/R12 reset pulse", sysRstOut, (mp != 0));
          chk("R5 no irq in mode 0", wdtIrq, 0);
        end
      end
    end

    // Mode 1 sweep: R7 R8
    for (int n = 0; n < 4; n++) begin
      for (int c = 0; c < 3; c++) begin
        doReset();
        wr(3'd1, 32'(n));
        p = (1 << (BASE + n)) - 1; t = p + 1; l = 2 << c; mp = 0; mi = 0;
        wr(3'd0, 32'((c << 2) | 3));
        for (int k = 0; k <= 2 * t + l + 2; k++) begin
          if (k > 0) begin
            @(negedge clk);
            tmo = (k % t) == 0;
            esc = tmo && (mi != 0);
            if (tmo) mi = 1;
            if (esc && mp == 0) mp = l;
            else if (mp != 0) mp--;
          end
          chk("R7 irq state", wdtIrq, mi);
          chk("R8 escalated reset", sysRstOut, (mp != 0));
          rd(3'd3, v);
          chk("R3 count in mode 1", v, p - (k % t));
        end
      end
    end

    // Directed: R11 R9 R10 R8 (range 3 -> preset 31, period 32)
    doReset();
    wr(3'd1, 32'd3);
    wr(3'd0, 32'd3);
    rd(3'd3, v); chk("R2 preset range 3", v, 31);
    wr(3'd0, 32'd2);
    rd(3'd0, v); chk("R11 still armed", v, 3);
    rd(3'd3, v); chk("R11 count keeps running", v, 29);
    wr(3'd2, 32'h75);
    rd(3'd3, v); chk("R9 wrong key ignored", v, 27);
    wr(3'd2, 32'h176);
    rd(3'd3, v); chk("R9 wrong upper bits ignored", v, 25);
    wr(3'd2, 32'h76);
    rd(3'd3, v); chk("R9 key reloads", v, 31);
    repeat (32) @(negedge clk);
    chk("R7 first timeout irq", wdtIrq, 1);
    rd(3'd4, v); chk("R10 status shows irq", v, 1);
    rd(3'd3, v); chk("R3 reload after timeout", v, 31);
    wr(3'd2, 32'h76);
    chk("R9 key clears irq", wdtIrq, 0);
    rd(3'd3, v); chk("R9 key reload value", v, 31);
    repeat (32) @(negedge clk);
    chk("R7 irq again", wdtIrq, 1);
    wr(3'd4, 32'd1);
    chk("R10 clear drops irq", wdtIrq, 0);
    rd(3'd3, v); chk("R10 clear keeps count", v, 29);
    rd(3'd4, v); chk("R10 status cleared", v, 0);
    repeat (30) @(negedge clk);
    chk("R10 timeout after clear is first stage", wdtIrq, 1);
    chk("R10 no reset after clear", sysRstOut, 0);
    repeat (31) @(negedge clk);
    chk("R8 no reset before second timeout", sysRstOut, 0);
    @(negedge clk);
    chk("R8 reset on second timeout", sysRstOut, 1);
    repeat (2) @(negedge clk);
    chk("R6 pulse of 2 cycles ended", sysRstOut, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule